// File: doc/BRIEF.md
# E1 Spare-Bit Multiframe Capture

This block sits on the receive side of an E1 framer, after frame alignment. For every frame of a 16-frame CRC4 multiframe, the framer hands it the timeslot-0 byte. With that byte it also gives the frame's position in the multiframe and says whether the frame carries the alignment word. From these bytes the block collects the international bits, the remote-alarm bits and the five national spare bits.

The bits build up in shadow shift registers. When the last frame of a multiframe arrives, the block copies all eight shadows into eight holding registers in one clock. A host reads these registers at its own pace. It has one multiframe period, 2 ms, before the next copy replaces them.

On each copy the block sets a sticky flag. The flag tells the host that fresh data is waiting. A read strobe from the host clears it.

Top module: `e1_spare_bit_capture`

## Requirements
- R1: After reset all eight holding registers read zero and the flag is low.
- R2: For frames marked as alignment frames, `si_align_q` collects byte bit 7 (line bit 1). The first of those frames in the multiframe lands in the MSB and the last in the LSB.
- R3: For non-alignment frames, `si_nonalign_q` collects byte bit 7 in the same order, with the first frame in the MSB.
- R4: For non-alignment frames, `alarm_q` collects byte bit 5 (line bit 3, the remote-alarm bit), with the first frame in the MSB.
- R5: For non-alignment frames, `sa4_q` through `sa8_q` collect byte bits 4, 3, 2, 1 and 0 respectively, with the first frame in the MSB.
- R6: The holding registers change only on the clock edge that accepts a valid byte with frame index 15 (`2*REG_W-1`). That edge loads all eight registers together, and the loaded values include the bits of that last frame.
- R7: The flag rises on the edge that accepts frame 15 and stays high until it is cleared.
- R8: A `rd_ack` pulse clears the flag on the next edge. If a multiframe boundary happens on that same edge, the flag stays set.
- R9: While `ts0_valid` is low, the byte, frame index and alignment inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts0_valid | input | 1 | A timeslot-0 byte is present this cycle |
| ts0_byte | input | 8 | Timeslot-0 byte; bit 7 is line bit 1 |
| frame_idx | input | 4 | Frame position in the multiframe, 0 to 15 |
| is_align | input | 1 | 1 when the frame carries the alignment word |
| rd_ack | input | 1 | Host read strobe that clears the flag |
| si_align_q | output | 8 | International bits of the alignment frames |
| si_nonalign_q | output | 8 | International bits of the non-alignment frames |
| alarm_q | output | 8 | Remote-alarm bits |
| sa4_q | output | 8 | Spare bit 4 |
| sa5_q | output | 8 | Spare bit 5 |
| sa6_q | output | 8 | Spare bit 6 |
| sa7_q | output | 8 | Spare bit 7 |
| sa8_q | output | 8 | Spare bit 8 |
| mf_flag | output | 1 | Sticky multiframe-ready flag |

## Verification
The bench builds the block with its default `REG_W` of 8. This gives the real 16-frame multiframe with eight bits per register, so every bit position in each register is checked against the frame it came from.

Idle cycles with random garbage on the inputs are mixed in between frames. Random host strobes are also applied, and one of them is placed on the boundary edge, which reaches the clear-versus-set priority. Patterns of all ones, all zeros and alternating bits make sure no register sticks at one value.

// File: rtl/e1_spare_bit_capture.sv
module e1_spare_bit_capture #(
  parameter int REG_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ts0_valid,
  input  logic [7:0]                    ts0_byte,
  input  logic [$clog2(2*REG_W)-1:0]    frame_idx,
  input  logic                          is_align,
  input  logic                          rd_ack,
  output logic [REG_W-1:0]              si_align_q,
  output logic [REG_W-1:0]              si_nonalign_q,
  output logic [REG_W-1:0]              alarm_q,
  output logic [REG_W-1:0]              sa4_q,
  output logic [REG_W-1:0]              sa5_q,
  output logic [REG_W-1:0]              sa6_q,
  output logic [REG_W-1:0]              sa7_q,
  output logic [REG_W-1:0]              sa8_q,
  output logic                          mf_flag
);
  localparam int NFRAMES = 2 * REG_W;
  localparam int IDX_W   = $clog2(NFRAMES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NFRAMES - 1);
  localparam int NSA = 5;

  logic [REG_W-1:0] sh_sia, sh_sin, sh_ra;
  logic [REG_W-1:0] sh_sa [NSA];
  logic [REG_W-1:0] eff_sia, eff_sin, eff_ra;
  logic [REG_W-1:0] eff_sa [NSA];
  logic [REG_W-1:0] hold_sa [NSA];

  wire take_a   = ts0_valid & is_align;
  wire take_n   = ts0_valid & ~is_align;
  wire boundary = ts0_valid & (frame_idx == LAST);

  assign eff_sia = take_a ? {sh_sia[REG_W-2:0], ts0_byte[7]} : sh_sia;
  assign eff_sin = take_n ? {sh_sin[REG_W-2:0], ts0_byte[7]} : sh_sin;
  assign eff_ra  = take_n ? {sh_ra[REG_W-2:0],  ts0_byte[5]} : sh_ra;

  always_comb
    for (int k = 0; k < NSA; k++)
      eff_sa[k] = take_n ? {sh_sa[k][REG_W-2:0], ts0_byte[4-k]} : sh_sa[k];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_sia <= '0; sh_sin <= '0; sh_ra <= '0;
      si_align_q <= '0; si_nonalign_q <= '0; alarm_q <= '0;
      for (int k = 0; k < NSA; k++) begin
        sh_sa[k]   <= '0;
        hold_sa[k] <= '0;
      end
      mf_flag <= 1'b0;
    end else begin
      sh_sia <= eff_sia; sh_sin <= eff_sin; sh_ra <= eff_ra;
      for (int k = 0; k < NSA; k++) sh_sa[k] <= eff_sa[k];
      if (boundary) begin
        si_align_q    <= eff_sia;
        si_nonalign_q <= eff_sin;
        alarm_q       <= eff_ra;
        for (int k = 0; k < NSA; k++) hold_sa[k] <= eff_sa[k];
      end
      mf_flag <= boundary | (mf_flag & ~rd_ack);
    end
  end

  assign sa4_q = hold_sa[0];
  assign sa5_q = hold_sa[1];
  assign sa6_q = hold_sa[2];
  assign sa7_q = hold_sa[3];
  assign sa8_q = hold_sa[4];

  a_r6_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !(ts0_valid && frame_idx == LAST) |=>
      $stable(si_align_q) && $stable(si_nonalign_q) && $stable(alarm_q) &&
      $stable(sa4_q) && $stable(sa8_q));

  a_r7_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (ts0_valid && frame_idx == LAST) |=> mf_flag);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_flag && !rd_ack) |=> mf_flag);

  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !(ts0_valid && frame_idx == LAST)) |=> !mf_flag);

  a_r4_alarm_last: assert property (@(posedge clk) disable iff (!rst_n)
    (ts0_valid && frame_idx == LAST && !is_align) |=> alarm_q[0] == $past(ts0_byte[5]));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ts0_valid && !rd_ack) |=> $stable(mf_flag) && $stable(sa6_q));
endmodule

// File: tb/tb_e1_spare_bit_capture.sv
module tb_e1_spare_bit_capture;
  localparam int REG_W = 8;
  localparam int NF = 2 * REG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ts0_valid = 1'b0;
  logic [7:0] ts0_byte = '0;
  logic [3:0] frame_idx = '0;
  logic is_align = 1'b0;
  logic rd_ack = 1'b0;
  logic [7:0] si_align_q, si_nonalign_q, alarm_q, sa4_q, sa5_q, sa6_q, sa7_q, sa8_q;
  logic mf_flag;

  always #5 clk = ~clk;

  e1_spare_bit_capture #(.REG_W(REG_W)) dut (
    .clk(clk), .rst_n(rst_n), .ts0_valid(ts0_valid), .ts0_byte(ts0_byte),
    .frame_idx(frame_idx), .is_align(is_align), .rd_ack(rd_ack),
    .si_align_q(si_align_q), .si_nonalign_q(si_nonalign_q), .alarm_q(alarm_q),
    .sa4_q(sa4_q), .sa5_q(sa5_q), .sa6_q(sa6_q), .sa7_q(sa7_q), .sa8_q(sa8_q),
    .mf_flag(mf_flag));

  int vectors = 0;
  int errors = 0;
  logic [7:0] mf [NF];
  logic [7:0] exp_r [8];
  logic exp_flag = 1'b0;

  function automatic logic [7:0] gather(int bitpos, bit want_align);
    logic [7:0] r = '0;
    for (int f = 0; f < NF; f++)
      if (((f % 2) == 0) == want_align) r = {r[6:0], mf[f][bitpos]};
    return r;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({"R2 ", tag}, si_align_q, exp_r[0]);
    check({"R3 ", tag}, si_nonalign_q, exp_r[1]);
    check({"R4 ", tag}, alarm_q, exp_r[2]);
    check({"R5 sa4 ", tag}, sa4_q, exp_r[3]);
    check({"R5 sa5 ", tag}, sa5_q, exp_r[4]);
    check({"R5 sa6 ", tag}, sa6_q, exp_r[5]);
    check({"R5 sa7 ", tag}, sa7_q, exp_r[6]);
    check({"R5 sa8 ", tag}, sa8_q, exp_r[7]);
  endtask

  task automatic cycle(bit v, logic [3:0] idx, logic [7:0] b, bit al, bit ack);
    ts0_valid = v; frame_idx = idx; ts0_byte = b; is_align = al; rd_ack = ack;
    @(negedge clk);
    exp_flag = (v && idx == 4'(NF-1)) ? 1'b1 : (ack ? 1'b0 : exp_flag);
    check(v ? "R7/R8 flag" : "R9 flag idle", {7'b0, mf_flag}, {7'b0, exp_flag});
  endtask

  task automatic run_mf(int mode, bit ack_at_end);
    for (int f = 0; f < NF; f++) begin
      case (mode)
        0: mf[f] = 8'($urandom);
        1: mf[f] = 8'hFF;
        2: mf[f] = 8'h00;
        default: mf[f] = (f % 2) ? 8'hAA : 8'h55;
      endcase
    end
    for (int f = 0; f < NF; f++) begin
      while ($urandom_range(0, 3) == 0) begin
        cycle(1'b0, 4'(NF-1), 8'($urandom), 1'($urandom), 1'b0);
        check_all("R9 idle");
      end
      if (f == NF - 1) begin
        cycle(1'b1, 4'(f), mf[f], (f % 2) == 0, ack_at_end);
        exp_r[0] = gather(7, 1'b1);
        exp_r[1] = gather(7, 1'b0);
        exp_r[2] = gather(5, 1'b0);
        for (int k = 0; k < 5; k++) exp_r[3+k] = gather(4 - k, 1'b0);
        check_all("R6 boundary");
      end else begin
        cycle(1'b1, 4'(f), mf[f], (f % 2) == 0, ($urandom_range(0, 4) == 0));
        check_all("R6 mid");
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 8; k++) exp_r[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    check("R1 flag reset", {7'b0, mf_flag}, 8'h00);
    run_mf(1, 1'b0);
    run_mf(2, 1'b1);
    check("R8 boundary beats read", {7'b0, mf_flag}, 8'h01);
    run_mf(3, 1'b0);
    for (int i = 0; i < 3; i++) cycle(1'b0, 4'd15, 8'hFF, 1'b0, 1'b0);
    check("R7 flag sticky", {7'b0, mf_flag}, 8'h01);
    cycle(1'b0, 4'd15, 8'hFF, 1'b0, 1'b1);
    check("R8 read clears", {7'b0, mf_flag}, 8'h00);
    for (int m = 0; m < 40; m++) run_mf(0, 1'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule